// File: doc/BRIEF.md
# Qualified Trigger Trace Buffer

This block records a wide bus sample into a 256-entry circular on-chip memory. A sample strobe marks each bus cycle. The block stores that cycle's 64-bit word only when the trace-qualifier input is high, so unwanted cycles use no storage. One of three event inputs is chosen as the trigger. After the trigger, a programmable number of further qualified cycles are still recorded. Recording then halts, so the memory holds history from both before and after the event.

A small host register port loads the post-trigger delay and the control settings. Each control write re-arms capture. A clear command rewinds the write pointer and drops the wrap flag. The write pointer and the wrap flag tell the host where the oldest entry sits. Once capture has halted, the host reads entries through a read port with one clock of latency.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset, `done` is 0, `wrapped` is 0 and `wr_ptr` is 0.
- R2: Strobe edge k registers `smp_word`, `smp_qual` and `smp_evt`; a qualified sample is written at `wr_ptr` on edge k+1, and `wr_ptr` advances by one on that same edge k+1.
- R3: A strobed sample with `smp_qual` low is not stored and leaves `wr_ptr` unchanged.
- R4: Control bits [2:1] choose the trigger: code 0, 1 or 2 picks `smp_evt[0]`, `smp_evt[1]` or `smp_evt[2]`; code 3 disables triggering.
- R5: Delay D is held in the delay register (`cfg_addr`=1, low DLY_W bits). After a trigger strobe, the first qualified sample at or after it is stored, then D more qualified samples are stored. `done` then rises, and later strobes store nothing.
- R6: With D=0, a qualified trigger strobe is the last entry stored. With D=0 and an unqualified trigger strobe, the next qualified sample is the last entry stored.
- R7: A trigger that arrives after the first trigger since arming does not restart the delay count.
- R8: `wrapped` goes to 1 when `wr_ptr` rolls from 255 to 0 and then stays at 1. Control bit 3 is a clear command: it sets `wr_ptr` and `wrapped` to 0.
- R9: `rd_data` shows the entry at `rd_addr` one clock after the address is applied.
- R10: A control write (`cfg_addr`=0) clears `done` and forgets any earlier trigger. Control bit 0 is the enable; while it is 0, no sample is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | Sample strobe, one clock per bus cycle |
| smp_word | input | 64 | Sampled bus word |
| smp_qual | input | 1 | Trace qualifier |
| smp_evt | input | 3 | Candidate trigger events |
| cfg_we | input | 1 | Host register write |
| cfg_addr | input | 1 | 0 = control, 1 = delay |
| cfg_wdata | input | 8 | Host write data |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 64 | Stored entry, one clock after the address |
| done | output | 1 | Capture halted after the trigger |
| wr_ptr | output | 8 | Next write address |
| wrapped | output | 1 | Pointer has rolled over since the last clear |

## Verification
The trigger and a qualified store can fall on the same strobe. When the delay is zero, the trigger strobe must then also be the one that halts capture. The bench provokes this by strobing a qualified word with the selected event high. It judges the result by checking that `done` and a single pointer step appear together on the clock after the strobe edge. The bench also repeats the event during a countdown and checks that the halt still arrives on the qualified sample counted from the first trigger.

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer #(
  parameter int SMP_W = 64,
  parameter int PTR_W = 8,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic [SMP_W-1:0] smp_word,
  input  logic             smp_qual,
  input  logic [2:0]       smp_evt,
  input  logic             cfg_we,
  input  logic             cfg_addr,
  input  logic [DLY_W-1:0] cfg_wdata,
  input  logic [PTR_W-1:0] rd_addr,
  output logic [SMP_W-1:0] rd_data,
  output logic             done,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             wrapped
);
  localparam int DEPTH = 1 << PTR_W;
  localparam int HALF  = PTR_W / 2;

  logic [SMP_W-1:0] mem [DEPTH];

  logic             en;
  logic [1:0]       tsel;
  logic [DLY_W-1:0] dly;
  logic [DLY_W-1:0] cnt;
  logic             trig_seen;

  logic [SMP_W-1:0] s_word;
  logic             s_qual;
  logic             s_trg;

  logic [HALF-1:0]        ptr_lo;
  logic [PTR_W-HALF-1:0]  ptr_hi;

  logic             ctrl_we, clr_cmd, trg_raw, live, hit, s_go, armed_now;
  logic [DLY_W-1:0] cnt_eff;

  assign ctrl_we = cfg_we && !cfg_addr;
  assign clr_cmd = ctrl_we && cfg_wdata[3];
  assign wr_ptr  = {ptr_hi, ptr_lo};

  always_comb begin
    case (tsel)
      2'd0:    trg_raw = smp_evt[0];
      2'd1:    trg_raw = smp_evt[1];
      2'd2:    trg_raw = smp_evt[2];
      default: trg_raw = 1'b0;
    endcase
  end

  assign live      = en && !done;
  assign hit       = live && s_trg && !trig_seen;
  assign s_go      = live && s_qual;
  assign armed_now = trig_seen || hit;
  assign cnt_eff   = hit ? dly : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b0;
      tsel <= 2'd3;
      dly  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr) dly <= cfg_wdata;
      else begin
        en   <= cfg_wdata[0];
        tsel <= cfg_wdata[2:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_word <= '0;
      s_qual <= 1'b0;
      s_trg  <= 1'b0;
    end else begin
      s_qual <= smp_stb && smp_qual;
      s_trg  <= smp_stb && trg_raw;
      if (smp_stb) s_word <= smp_word;
    end
  end

  always_ff @(posedge clk) begin
    if (s_go) mem[wr_ptr] <= s_word;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_lo  <= '0;
      ptr_hi  <= '0;
      wrapped <= 1'b0;
    end else if (clr_cmd) begin
      ptr_lo  <= '0;
      ptr_hi  <= '0;
      wrapped <= 1'b0;
    end else if (s_go) begin
      ptr_lo <= ptr_lo + 1'b1;
      if (&ptr_lo) ptr_hi <= ptr_hi + 1'b1;
      if (&wr_ptr) wrapped <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      trig_seen <= 1'b0;
      cnt       <= '0;
    end else if (ctrl_we) begin
      done      <= 1'b0;
      trig_seen <= 1'b0;
    end else if (live) begin
      if (hit) trig_seen <= 1'b1;
      if (s_go && armed_now) begin
        if (cnt_eff == '0) done <= 1'b1;
        else cnt <= cnt_eff - 1'b1;
      end else if (hit) begin
        cnt <= dly;
      end
    end
  end

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_go && !clr_cmd) |=> wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)); // R2
  AST_UNQUAL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_qual && !clr_cmd) |=> $stable(wr_ptr)); // R3
  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_we) |=> done && $stable(wr_ptr)); // R5
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrapped && !clr_cmd) |=> wrapped); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_cmd |=> (!wrapped && wr_ptr == '0)); // R8
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !done); // R10
endmodule

// File: tb/test_trace_capture_buffer.sv
module test_trace_capture_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic [63:0] smp_word = '0;
  logic        smp_qual = 1'b0;
  logic [2:0]  smp_evt = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        done;
  logic [7:0]  wr_ptr;
  logic        wrapped;

  int total = 0;
  int bad = 0;
  logic [7:0] eptr;

  always #5 clk = ~clk;

  trace_capture_buffer i_trace_capture_buffer (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_word(smp_word),
    .smp_qual(smp_qual), .smp_evt(smp_evt), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .wr_ptr(wr_ptr), .wrapped(wrapped));

  // {qual, evt[2:0], expected wr_ptr, expected done}; delay 2, trigger on evt[1]
  localparam logic [12:0] VEC [9] = '{
    {1'b1, 3'b000, 8'd1, 1'b0},
    {1'b0, 3'b000, 8'd1, 1'b0},
    {1'b1, 3'b001, 8'd2, 1'b0},
    {1'b0, 3'b010, 8'd2, 1'b0},
    {1'b1, 3'b000, 8'd3, 1'b0},
    {1'b1, 3'b010, 8'd4, 1'b0},
    {1'b0, 3'b000, 8'd4, 1'b0},
    {1'b1, 3'b000, 8'd5, 1'b1},
    {1'b1, 3'b000, 8'd5, 1'b1}
  };
  localparam int STORED [5] = '{0, 2, 4, 5, 7};

  function automatic logic [63:0] pat(input int i);
    return {8{8'(i)}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic smp(input logic [63:0] w, input logic q, input logic [2:0] e);
    @(negedge clk);
    smp_stb = 1'b1; smp_word = w; smp_qual = q; smp_evt = e;
    @(negedge clk);
    smp_stb = 1'b0; smp_qual = 1'b0; smp_evt = '0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [63:0] exp, input string req);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 wrapped", wrapped, 0);
    chk("R1 wr_ptr", wr_ptr, 0);
    rst_n = 1'b1;

    cfg(1'b1, 8'd2);
    cfg(1'b0, 8'b0000_1011);
    for (int i = 0; i < 9; i++) begin
      smp(pat(i), VEC[i][12], VEC[i][11:9]);
      chk("R3 R5 R7 table wr_ptr", wr_ptr, VEC[i][8:1]);
      chk("R5 R7 table done", done, VEC[i][0]);
    end
    for (int k = 0; k < 5; k++) rd(8'(k), pat(STORED[k]), "R9 R5 readback");
    eptr = 8'd5;

    // R4 / R6: trigger on evt[0], delay 0, qualified trigger strobe
    cfg(1'b1, 8'd0);
    cfg(1'b0, 8'b0000_0001);
    chk("R10 rearm clears done", done, 0);
    smp(pat(20), 1'b1, 3'b010);
    eptr++;
    chk("R4 unselected event no halt", done, 0);
    smp(pat(21), 1'b1, 3'b001);
    eptr++;
    chk("R6 qualified trigger halts", done, 1);
    chk("R6 qualified trigger stored", wr_ptr, eptr);

    // R6: unqualified trigger, evt[2]
    cfg(1'b0, 8'b0000_0101);
    smp(pat(22), 1'b0, 3'b100);
    chk("R6 unqualified trigger not halted", done, 0);
    chk("R3 unqualified not stored", wr_ptr, eptr);
    smp(pat(23), 1'b1, 3'b000);
    eptr++;
    chk("R6 next qualified halts", done, 1);
    chk("R6 next qualified stored", wr_ptr, eptr);
    rd(eptr - 8'd1, pat(23), "R9 R6 last entry");

    // R4: code 3 disables triggering
    cfg(1'b0, 8'b0000_0111);
    smp(pat(24), 1'b1, 3'b111);
    eptr++;
    chk("R4 code 3 no trigger", done, 0);
    chk("R4 code 3 still stores", wr_ptr, eptr);

    // R10: enable off
    cfg(1'b0, 8'b0000_0110);
    smp(pat(25), 1'b1, 3'b000);
    chk("R10 disabled no store", wr_ptr, eptr);

    // R8 clear, R2 timing
    cfg(1'b0, 8'b0000_1111);
    chk("R8 clear ptr", wr_ptr, 0);
    chk("R8 clear wrapped", wrapped, 0);
    @(negedge clk);
    smp_stb = 1'b1; smp_word = pat(30); smp_qual = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; smp_qual = 1'b0;
    chk("R2 ptr unchanged after strobe edge", wr_ptr, 0);
    @(negedge clk);
    chk("R2 ptr advanced one edge later", wr_ptr, 1);
    rd(8'd0, pat(30), "R2 R9 entry content");

    // R8 wrap
    for (int i = 0; i < 254; i++) smp(pat(40 + i), 1'b1, 3'b000);
    chk("R8 ptr at top", wr_ptr, 255);
    chk("R8 not yet wrapped", wrapped, 0);
    smp(pat(300), 1'b1, 3'b000);
    chk("R8 ptr rolled", wr_ptr, 0);
    chk("R8 wrapped set", wrapped, 1);
    smp(pat(301), 1'b1, 3'b000);
    chk("R8 wrapped sticky", wrapped, 1);
    cfg(1'b0, 8'b0000_1111);
    chk("R8 clear drops wrap", wrapped, 0);
    chk("R8 clear zeroes ptr", wr_ptr, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule